// File: doc/BRIEF.md
# Compare Output Pin Controller

This block sits beside the compare channels of a timer. Each channel holds one internal output-compare level. A compare match pulse from the counter can leave that level alone, toggle it, clear it or set it, as a 2-bit action field selects. In non-PWM operation, a force strobe applies the same action at once, with no match needed. The level is held in a two-state machine per channel, with the states `OC_LOW` and `OC_HIGH`. The transitions are `SET_EVT` (to `OC_HIGH`), `CLR_EVT` (to `OC_LOW`) and `TGL_EVT` (to the opposite state). Each transition is taken on the clock edge that follows a qualifying event. With no event, or with action `00`, the state stays as it is.

Each channel also decides what its pin shows. If either action bit is nonzero, the compare level replaces the general port data bit. The pin's output enable always follows the channel's direction bit. Software can therefore preset the compare level with the pin still set as an input, and then turn on the output. The action field is read at the moment an event occurs. A rewrite therefore takes effect at the next match, and nothing changes earlier.

Top module: `cmp_out_ctrl`

## Requirements
- R1: Reset puts every channel in `OC_LOW`. After reset, with a nonzero action field, `pin_out` reads 0.
- R2: Action `00` (none) leaves the state unchanged on a match.
- R3: Action `01` (toggle) inverts the state on the clock edge that samples a match.
- R4: On a match, action `10` (clear) gives `OC_LOW` and action `11` (set) gives `OC_HIGH`.
- R5: With `non_pwm` high, a force strobe applies the selected action on the next edge without a match. A force and a match in the same cycle apply the action once.
- R6: With `non_pwm` low, a force strobe has no effect on the state.
- R7: Changing the action field with no match or force leaves the state unchanged. The new value is first used at the next event.
- R8: With a nonzero action field, `pin_out` shows the channel state. With action `00`, it shows `port_data`.
- R9: `pin_oe` equals the channel's `ddr` bit in every action mode.
- R10: A state written while `ddr` is 0 is kept, and appears with `pin_oe` high once `ddr` is raised.
- R11: Each channel's state responds only to its own `match` and `force` bits. Channel i uses action bits [2i+1:2i].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| non_pwm | input | 1 | High when the timer is in a non-PWM mode; enables force |
| match | input | NUM_CH | Per-channel compare match pulse |
| force_stb | input | NUM_CH | Per-channel force strobe |
| act_mode | input | 2*NUM_CH | Per-channel action field: 00 none, 01 toggle, 10 clear, 11 set |
| port_data | input | NUM_CH | General port data bit per channel |
| ddr | input | NUM_CH | Direction bit per channel, 1 = output |
| pin_out | output | NUM_CH | Value driven toward the pin |
| pin_oe | output | NUM_CH | Pin output enable |

## Verification
The case hardest to reach from the ports is a state change made under action `00`, or one made while the pin is an input. The compare level cannot be seen directly at such times. The bench makes it visible by switching the action field to a nonzero value in a later cycle that has no match, so `pin_out` then shows the held level. It does the same by raising `ddr` after a preset. A force that meets a match in the same cycle is driven under toggle, where a double application would show up as no change.

// File: rtl/cmp_out_pkg.sv
package cmp_out_pkg;

    typedef enum logic [1:0] {
        ACT_NONE   = 2'b00,
        ACT_TOGGLE = 2'b01,
        ACT_CLEAR  = 2'b10,
        ACT_SET    = 2'b11
    } oc_act_e;

    typedef enum logic {
        OC_LOW  = 1'b0,
        OC_HIGH = 1'b1
    } oc_state_e;

endpackage

// File: rtl/cmp_out_event.sv
module cmp_out_event
    import cmp_out_pkg::*;
(
    input  logic       match,
    input  logic       force_stb,
    input  logic       non_pwm,
    input  logic [1:0] act_mode,
    output logic       fire,
    output oc_act_e    act
);
    // A force strobe only counts in non-PWM operation (R5, R6).
    always_comb begin
        fire = match | (force_stb & non_pwm);
        act  = oc_act_e'(act_mode);
    end
endmodule

// File: rtl/cmp_out_state.sv
module cmp_out_state
    import cmp_out_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    fire,
    input  oc_act_e act,
    output logic    oc_level
);
    oc_state_e state_q, state_d;

    // State register.
    always_ff @(posedge clk) begin
        if (rst) state_q <= OC_LOW;
        else     state_q <= state_d;
    end

    // Transitions: SET_EVT, CLR_EVT, TGL_EVT.
    always_comb begin
        state_d = state_q;
        if (fire) begin
            unique case (act)
                ACT_NONE:   state_d = state_q;
                ACT_TOGGLE: state_d = (state_q == OC_HIGH) ? OC_LOW : OC_HIGH;
                ACT_CLEAR:  state_d = OC_LOW;
                ACT_SET:    state_d = OC_HIGH;
            endcase
        end
    end

    // Output.
    always_comb begin
        oc_level = (state_q == OC_HIGH);
    end

    a_r1_reset_low: assert property (@(posedge clk) rst |=> !oc_level);
    a_r2_none_holds: assert property (@(posedge clk) disable iff (rst)
        (fire && act == ACT_NONE) |=> $stable(oc_level));
    a_r3_toggle_flips: assert property (@(posedge clk) disable iff (rst)
        (fire && act == ACT_TOGGLE) |=> (oc_level != $past(oc_level)));
    a_r4_clear_low: assert property (@(posedge clk) disable iff (rst)
        (fire && act == ACT_CLEAR) |=> !oc_level);
    a_r4_set_high: assert property (@(posedge clk) disable iff (rst)
        (fire && act == ACT_SET) |=> oc_level);
    a_r7_idle_stable: assert property (@(posedge clk) disable iff (rst)
        !fire |=> $stable(oc_level));
endmodule

// File: rtl/cmp_out_pinmux.sv
module cmp_out_pinmux (
    input  logic [1:0] act_mode,
    input  logic       oc_level,
    input  logic       port_data,
    input  logic       ddr,
    output logic       pin_out,
    output logic       pin_oe
);
    logic takeover;

    always_comb begin
        takeover = |act_mode;
        pin_out  = takeover ? oc_level : port_data;
        pin_oe   = ddr;
    end
endmodule

// File: rtl/cmp_out_ctrl.sv
module cmp_out_ctrl #(
    parameter int NUM_CH = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  non_pwm,
    input  logic [NUM_CH-1:0]     match,
    input  logic [NUM_CH-1:0]     force_stb,
    input  logic [2*NUM_CH-1:0]   act_mode,
    input  logic [NUM_CH-1:0]     port_data,
    input  logic [NUM_CH-1:0]     ddr,
    output logic [NUM_CH-1:0]     pin_out,
    output logic [NUM_CH-1:0]     pin_oe
);
    import cmp_out_pkg::*;

    localparam int ACT_W = 2;

    logic [NUM_CH-1:0] oc_lvl;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic       fire;
        oc_act_e    act;
        logic [ACT_W-1:0] mode_i;

        assign mode_i = act_mode[ACT_W*i +: ACT_W];

        cmp_out_event u_event (
            .match     (match[i]),
            .force_stb (force_stb[i]),
            .non_pwm   (non_pwm),
            .act_mode  (mode_i),
            .fire      (fire),
            .act       (act)
        );

        cmp_out_state u_state (
            .clk      (clk),
            .rst      (rst),
            .fire     (fire),
            .act      (act),
            .oc_level (oc_lvl[i])
        );

        cmp_out_pinmux u_pinmux (
            .act_mode  (mode_i),
            .oc_level  (oc_lvl[i]),
            .port_data (port_data[i]),
            .ddr       (ddr[i]),
            .pin_out   (pin_out[i]),
            .pin_oe    (pin_oe[i])
        );

        a_r6_force_ignored: assert property (@(posedge clk) disable iff (rst)
            (!match[i] && !non_pwm) |=> $stable(oc_lvl[i]));
        a_r8_pin_shows_state: assert property (@(posedge clk) disable iff (rst)
            (mode_i != 2'b00) |-> (pin_out[i] == oc_lvl[i]));
        a_r5_force_applies_set: assert property (@(posedge clk) disable iff (rst)
            (force_stb[i] && non_pwm && mode_i == 2'b11) |=> oc_lvl[i]);
    end
endmodule

// File: tb/cmp_out_ctrl_bench.sv
module cmp_out_ctrl_bench;
    localparam int NUM_CH = 2;
    localparam int NVEC   = 17;

    logic clk = 1'b0;
    logic rst;
    logic non_pwm;
    logic [NUM_CH-1:0]   match, force_stb, port_data, ddr;
    logic [2*NUM_CH-1:0] act_mode;
    logic [NUM_CH-1:0]   pin_out, pin_oe;

    int tests  = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    cmp_out_ctrl #(.NUM_CH(NUM_CH)) u_cmp_out_ctrl (
        .clk, .rst, .non_pwm, .match, .force_stb, .act_mode,
        .port_data, .ddr, .pin_out, .pin_oe
    );

    // {match, force, non_pwm, mode[1:0], port, ddr, exp_out, exp_oe} for channel 0
    localparam logic [8:0] VEC [NVEC] = '{
        9'b0_0_1_01_1_1_0_1, // R8 state 0 shown
        9'b1_0_1_01_1_1_1_1, // R3 toggle up
        9'b1_0_1_01_1_1_0_1, // R3 toggle down
        9'b1_0_1_11_1_1_1_1, // R4 set
        9'b1_0_1_10_1_1_0_1, // R4 clear
        9'b0_0_1_11_1_1_0_1, // R7 mode change only
        9'b1_0_1_00_1_1_1_1, // R2 none, pin shows port
        9'b0_0_1_11_0_1_0_1, // R2 state still 0
        9'b0_1_1_11_0_1_1_1, // R5 force set
        9'b0_1_0_10_0_1_1_1, // R6 force ignored
        9'b1_1_1_01_0_1_0_1, // R5 force+match toggles once
        9'b0_0_1_00_0_0_0_0, // R9 oe low, port shown
        9'b0_0_1_00_1_0_1_0, // R9 R8 port shown
        9'b0_1_1_11_0_0_1_0, // R10 preset while input
        9'b0_0_1_11_0_1_1_1, // R10 enable output
        9'b1_0_1_00_0_1_0_1, // R2 none keeps 1, port shown
        9'b0_0_1_10_0_1_1_1  // R7 R2 held 1 visible
    };

    task automatic check(input string req, input logic act, input logic exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    task automatic step;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; non_pwm = 1'b1; match = '0; force_stb = '0;
        act_mode = '0; port_data = '0; ddr = '0;
        step(); step();
        rst = 1'b0;
        act_mode = 4'b0111;  // ch1 toggle, ch0 set mode
        ddr = 2'b11;
        #1;
        check("R1 ch0 after reset", pin_out[0], 1'b0);
        check("R1 ch1 after reset", pin_out[1], 1'b0);

        for (int k = 0; k < NVEC; k++) begin
            match[0]     = VEC[k][8];
            force_stb[0] = VEC[k][7];
            non_pwm      = VEC[k][6];
            act_mode[1:0]= VEC[k][5:4];
            port_data[0] = VEC[k][3];
            ddr[0]       = VEC[k][2];
            step();
            check($sformatf("vec%0d pin_out", k), pin_out[0], VEC[k][1]);
            check($sformatf("vec%0d R9 pin_oe", k), pin_oe[0], VEC[k][0]);
        end
        match = '0; force_stb = '0; non_pwm = 1'b1;

        // R11: channel 1 untouched by channel 0 activity
        check("R11 ch1 idle", pin_out[1], 1'b0);
        match[1] = 1'b1;
        step();
        match[1] = 1'b0;
        check("R11 ch1 own match toggles", pin_out[1], 1'b1);
        check("R11 ch0 unaffected", pin_out[0], 1'b1);

        // R1: reset while state is high
        rst = 1'b1;
        step();
        rst = 1'b0;
        act_mode = 4'b1111;
        #1;
        check("R1 mid-run reset ch0", pin_out[0], 1'b0);
        check("R1 mid-run reset ch1", pin_out[1], 1'b0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule